// File: doc/BRIEF.md
# Strip Cluster Width Discriminator

This block receives one snapshot per bunch crossing of binary hit bits from a front end that serves two interleaved sensor layers. It removes masked channels, splits the channels into the two layers, and looks for runs of adjacent hit strips (clusters) inside each layer. A cluster of one, two or three strips is accepted and its centre is reported at half-strip resolution. A cluster of four or more strips is dropped. A global flag reports whether any unmasked channel on this chip is hit.

Hit bits from the nearest two strips of each layer on the chips to either side come in through neighbour ports. A cluster that crosses a chip edge is therefore judged on its full width. Each half-strip centre position is owned by exactly one chip, so such a cluster is reported by one chip only. Snapshots enter through a valid/ready handshake. Results leave through a one-entry registered valid/ready stage that feeds a downstream correlation stage.

Back-pressure rules:
- A snapshot transfers on a clock edge where `in_valid` and `in_ready` are both high.
- Its result appears with `out_valid` on the next cycle.
- While `out_valid` is high and `out_ready` is low, the result is held unchanged and `in_ready` is low.

Top module: `strip_cluster_filter`

## Requirements
- R1: Channel index 2k (0-based) of `hit_in` and `mask_in` is strip k of layer A, and channel 2k+1 is strip k of layer B. In each neighbour port, bit 2j is layer A and bit 2j+1 is layer B, at distance j+1 strips from the chip edge. In `nbr_lo`, distance 1 is strip -1; in `nbr_hi`, distance 1 is strip N_STRIP.
- R2: A channel whose `mask_in` bit is 1 is treated as not hit, both for clustering and for `any_hit`.
- R3: A run of 1, 2 or 3 hit strips bounded on both sides by empty strips is accepted. A run of 4 or more strips produces no centre bit.
- R4: An accepted cluster with first strip s and last strip e sets bit s+e of its layer's centre vector (`ctr_a` for layer A, `ctr_b` for layer B). Neighbour strips take the indices -2, -1, N_STRIP and N_STRIP+1.
- R5: Only centres in 0..2*N_STRIP-1 are reported, so the midpoint between the last own strip and the first upper-neighbour strip belongs to this chip. Strips farther than two from either edge are treated as empty.
- R6: `any_hit` is the OR of all unmasked own channels. Neighbour bits do not affect it.
- R7: A snapshot accepted at one clock edge produces its result with `out_valid` high after that edge. With no accepted input and `out_ready` high, `out_valid` is low on the next cycle.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `ctr_a`, `ctr_b` and `any_hit` hold their values.
- R9: After reset, `out_valid` is 0, `in_ready` is 1, and `ctr_a`, `ctr_b` and `any_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Snapshot on the inputs is valid |
| in_ready | output | 1 | Block can take a snapshot |
| hit_in | input | 2*N_STRIP | Interleaved per-channel hit bits |
| mask_in | input | 2*N_STRIP | Per-channel mask, 1 = blocked |
| nbr_lo | input | 4 | Hits of the two nearest strips per layer on the lower neighbour chip |
| nbr_hi | input | 4 | Hits of the two nearest strips per layer on the upper neighbour chip |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| ctr_a | output | 2*N_STRIP | Half-strip centre bits of accepted layer A clusters |
| ctr_b | output | 2*N_STRIP | Half-strip centre bits of accepted layer B clusters |
| any_hit | output | 1 | Any unmasked own channel hit |

## Verification
Three 256-pattern sweeps are run against an arithmetic run-length model:
- all patterns of eight adjacent channels in mid-chip, which shows whether the two layers are split correctly;
- all patterns of six layer A strips plus both lower-neighbour strips, which separates accepted clusters from vetoed ones and centres inside the chip from centres owned by the neighbour chip;
- the same sweep at the upper edge in layer B.

Random full-width vectors with random masks test masking against dense and sparse occupancy. Fixed cases cover all channels hit, all channels masked, and hits on neighbour strips only. A stalled consumer followed by a release shows that the held result and the refused input are kept apart.

// File: rtl/scw_pkg.sv
package scw_pkg;
  // strips per layer taken from each neighbouring chip
  localparam int unsigned NBR_DEPTH = 2;
  // widest cluster that is still accepted
  localparam int unsigned MAX_WIDTH = 3;
endpackage

// File: rtl/scw_layer_split.sv
module scw_layer_split
  import scw_pkg::*;
#(
  parameter int unsigned N_STRIP = 127
) (
  input  logic [2*N_STRIP-1:0]           hit_in,
  input  logic [2*N_STRIP-1:0]           mask_in,
  input  logic [2*NBR_DEPTH-1:0]         nbr_lo,
  input  logic [2*NBR_DEPTH-1:0]         nbr_hi,
  output logic [N_STRIP+2*NBR_DEPTH-1:0] ext_a,
  output logic [N_STRIP+2*NBR_DEPTH-1:0] ext_b,
  output logic                           any_hit
);
  localparam int unsigned NCH = 2 * N_STRIP;

  logic [NCH-1:0] live;

  assign live    = hit_in & ~mask_in;
  assign any_hit = |live;

  // extended index i stands for strip i - NBR_DEPTH
  for (genvar k = 0; k < N_STRIP; k++) begin : g_own
    assign ext_a[k+NBR_DEPTH] = live[2*k];
    assign ext_b[k+NBR_DEPTH] = live[2*k+1];
  end

  for (genvar j = 0; j < NBR_DEPTH; j++) begin : g_nbr
    assign ext_a[NBR_DEPTH-1-j]         = nbr_lo[2*j];
    assign ext_b[NBR_DEPTH-1-j]         = nbr_lo[2*j+1];
    assign ext_a[N_STRIP+NBR_DEPTH+j]   = nbr_hi[2*j];
    assign ext_b[N_STRIP+NBR_DEPTH+j]   = nbr_hi[2*j+1];
  end
endmodule

// File: rtl/scw_cluster_finder.sv
module scw_cluster_finder
  import scw_pkg::*;
#(
  parameter int unsigned N_STRIP = 127
) (
  input  logic [N_STRIP+2*NBR_DEPTH-1:0] ext,
  output logic [2*N_STRIP-1:0]           ctr
);
  localparam int unsigned NPOS = 2 * N_STRIP;

  // Each centre position p has a fixed set of strip windows that can
  // produce it: odd p from a pair, even p from a single or a triple.
  for (genvar p = 0; p < NPOS; p++) begin : g_pos
    if (p % 2 == 1) begin : g_pair
      localparam int unsigned S = (p - 1) / 2 + NBR_DEPTH;
      assign ctr[p] = ext[S] & ext[S+1] & ~ext[S-1] & ~ext[S+2];
    end else begin : g_odd_width
      localparam int unsigned K = p / 2 + NBR_DEPTH;
      logic single_hit;
      logic triple_hit;
      assign single_hit = ext[K] & ~ext[K-1] & ~ext[K+1];
      if (MAX_WIDTH >= 3) begin : g_tri
        assign triple_hit = ext[K-1] & ext[K] & ext[K+1]
                          & ~ext[K-2] & ~ext[K+2];
      end else begin : g_no_tri
        assign triple_hit = 1'b0;
      end
      assign ctr[p] = single_hit | triple_hit;
    end
  end
endmodule

// File: rtl/scw_out_stage.sv
module scw_out_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/strip_cluster_filter.sv
module strip_cluster_filter
  import scw_pkg::*;
#(
  parameter int unsigned N_STRIP = 127
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [2*N_STRIP-1:0]   hit_in,
  input  logic [2*N_STRIP-1:0]   mask_in,
  input  logic [2*NBR_DEPTH-1:0] nbr_lo,
  input  logic [2*NBR_DEPTH-1:0] nbr_hi,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [2*N_STRIP-1:0]   ctr_a,
  output logic [2*N_STRIP-1:0]   ctr_b,
  output logic                   any_hit
);
  localparam int unsigned NPOS  = 2 * N_STRIP;
  localparam int unsigned NEXT  = N_STRIP + 2 * NBR_DEPTH;
  localparam int unsigned PAY_W = 2 * NPOS + 1;

  logic [NEXT-1:0]  ext_a, ext_b;
  logic [NPOS-1:0]  cen_a, cen_b;
  logic             any_c;
  logic [PAY_W-1:0] pay_in, pay_out;

  scw_layer_split #(.N_STRIP(N_STRIP)) split_i (
    .hit_in (hit_in),
    .mask_in(mask_in),
    .nbr_lo (nbr_lo),
    .nbr_hi (nbr_hi),
    .ext_a  (ext_a),
    .ext_b  (ext_b),
    .any_hit(any_c)
  );

  scw_cluster_finder #(.N_STRIP(N_STRIP)) find_a_i (.ext(ext_a), .ctr(cen_a));
  scw_cluster_finder #(.N_STRIP(N_STRIP)) find_b_i (.ext(ext_b), .ctr(cen_b));

  assign pay_in = {any_c, cen_b, cen_a};

  scw_out_stage #(.W(PAY_W)) out_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (pay_in),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (pay_out)
  );

  assign ctr_a   = pay_out[NPOS-1:0];
  assign ctr_b   = pay_out[2*NPOS-1:NPOS];
  assign any_hit = pay_out[PAY_W-1];
endmodule

// File: rtl/scw_checker.sv
module scw_checker #(
  parameter int unsigned N_STRIP = 127
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [2*N_STRIP-1:0] ctr_a,
  input logic [2*N_STRIP-1:0] ctr_b,
  input logic                 any_hit
);
  // R8: stalled result is frozen
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(ctr_a) && $stable(ctr_b)
                                && $stable(any_hit));

  // R8: stalled stage refuses input
  a_r8_refuse_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R7: accepted snapshot yields a result next cycle
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R6: any reported centre implies an own hit
  a_r6_centre_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ((|ctr_a) || (|ctr_b)) |-> any_hit);

  // R4: distinct clusters are at least four half-strips apart
  a_r4_no_adjacent_centres: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((ctr_a & (ctr_a >> 1)) == '0) && ((ctr_b & (ctr_b >> 1)) == '0));
endmodule

bind strip_cluster_filter scw_checker #(.N_STRIP(N_STRIP)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .ctr_a    (ctr_a),
  .ctr_b    (ctr_b),
  .any_hit  (any_hit)
);

// File: tb/strip_cluster_filter_tb.sv
module strip_cluster_filter_tb_top;
  localparam int N      = 127;
  localparam int NP     = 2 * N;
  localparam int PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [NP-1:0] hit_in = '0;
  logic [NP-1:0] mask_in = '0;
  logic [3:0]    nbr_lo = '0;
  logic [3:0]    nbr_hi = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [NP-1:0] ctr_a, ctr_b;
  logic          any_hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  strip_cluster_filter #(.N_STRIP(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .hit_in(hit_in), .mask_in(mask_in), .nbr_lo(nbr_lo), .nbr_hi(nbr_hi),
    .out_valid(out_valid), .out_ready(out_ready),
    .ctr_a(ctr_a), .ctr_b(ctr_b), .any_hit(any_hit)
  );

  // run-length reference of one layer; strips -2..N+1 mapped to 0..N+3
  function automatic logic [NP-1:0] layer_ref(input logic [NP-1:0] h,
      input logic [NP-1:0] m, input logic [3:0] lo, input logic [3:0] hi,
      input int lay);
    logic [N+3:0]  x;
    logic [NP-1:0] r;
    int i;
    r = '0;
    x[0] = lo[2+lay];
    x[1] = lo[lay];
    x[N+2] = hi[lay];
    x[N+3] = hi[2+lay];
    for (int k = 0; k < N; k++) x[k+2] = h[2*k+lay] & ~m[2*k+lay];
    i = 0;
    while (i < N + 4) begin
      if (x[i]) begin
        int j;
        int p;
        j = i;
        while (j + 1 < N + 4 && x[j+1]) j++;
        p = (i - 2) + (j - 2);
        if (j - i + 1 <= 3 && p >= 0 && p <= NP - 1) r[p] = 1'b1;
        i = j + 1;
      end else begin
        i++;
      end
    end
    return r;
  endfunction

  task automatic chk_vec(input string req, input string what,
                         input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input string what,
                         input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %b expected %b", req, what, act, exp);
    end
  endtask

  // drive one snapshot, let it pass the edge, compare at the next negedge
  task automatic apply(input string req, input logic [NP-1:0] h,
                       input logic [NP-1:0] m, input logic [3:0] lo,
                       input logic [3:0] hi);
    hit_in = h; mask_in = m; nbr_lo = lo; nbr_hi = hi; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk_bit(req, "out_valid", out_valid, 1'b1);
    chk_vec(req, "ctr_a", ctr_a, layer_ref(h, m, lo, hi, 0));
    chk_vec(req, "ctr_b", ctr_b, layer_ref(h, m, lo, hi, 1));
    chk_bit(req, "any_hit", any_hit, |(h & ~m));
  endtask

  function automatic logic [NP-1:0] rand_vec();
    logic [NP-1:0] v;
    for (int w = 0; w < 8; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    logic [NP-1:0] h, m, e;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk_bit("R9", "out_valid", out_valid, 1'b0);
    chk_bit("R9", "in_ready", in_ready, 1'b1);
    chk_vec("R9", "ctr_a", ctr_a, '0);
    chk_vec("R9", "ctr_b", ctr_b, '0);
    chk_bit("R9", "any_hit", any_hit, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 interleave: every pattern of channels 120..127 (strips 60..63)
    for (int v = 0; v < 256; v++) begin
      h = '0; h[127:120] = 8'(v);
      apply("R1", h, '0, 4'h0, 4'h0);
    end

    // R3 R4 R5 lower edge: layer A strips 0..5 plus strips -1,-2
    for (int v = 0; v < 256; v++) begin
      logic [3:0] lo;
      h = '0;
      for (int k = 0; k < 6; k++) h[2*k] = v[k+2];
      lo = {1'b0, v[1], 1'b0, v[0]};
      apply("R5_lo", h, '0, lo, 4'h0);
    end

    // R3 R4 R5 upper edge: layer B strips N-6..N-1 plus strips N, N+1
    for (int v = 0; v < 256; v++) begin
      logic [3:0] hi;
      h = '0;
      for (int k = 0; k < 6; k++) h[2*(N-6+k)+1] = v[k+2];
      hi = {v[1], 1'b0, v[0], 1'b0};
      apply("R5_hi", h, '0, 4'h0, hi);
    end

    // R4 explicit centre values
    h = '0; h[2*10] = 1'b1; h[2*11] = 1'b1;          // layer A strips 10,11
    e = '0; e[21] = 1'b1;
    apply("R4", h, '0, 4'h0, 4'h0);
    chk_vec("R4", "pair centre 21", ctr_a, e);
    h = '0; h[2*20+1] = 1'b1; h[2*21+1] = 1'b1; h[2*22+1] = 1'b1;
    e = '0; e[42] = 1'b1;
    apply("R4", h, '0, 4'h0, 4'h0);
    chk_vec("R4", "triple centre 42", ctr_b, e);

    // R3 all hit: one long run per layer, no centres
    apply("R3", '1, '0, 4'hF, 4'hF);
    chk_vec("R3", "wide run ctr_a", ctr_a, '0);
    // R2 all masked: nothing survives
    apply("R2", '1, '1, 4'h0, 4'h0);
    chk_bit("R2", "masked any_hit", any_hit, 1'b0);
    // R6 neighbour-only hits do not raise any_hit
    apply("R6", '0, '0, 4'hF, 4'hF);
    chk_bit("R6", "neighbour only any_hit", any_hit, 1'b0);

    // R2 R6 random occupancy and masks, sparse and dense
    for (int t = 0; t < 300; t++) begin
      h = rand_vec();
      if (t % 3 == 0) h = h & rand_vec() & rand_vec();
      m = rand_vec() & rand_vec();
      apply("R2", h, m, 4'($urandom), 4'($urandom));
    end

    // R7 idle cycle: no accepted input, out_valid drops
    @(negedge clk);
    chk_bit("R7", "out_valid after idle", out_valid, 1'b0);

    // R8 back-pressure
    out_ready = 1'b0;
    h = '0; h[2*50] = 1'b1;
    apply("R8", h, '0, 4'h0, 4'h0);
    hit_in = '0; hit_in[2*70+1] = 1'b1; in_valid = 1'b1;
    chk_bit("R8", "in_ready while stalled", in_ready, 1'b0);
    @(negedge clk);
    e = '0; e[100] = 1'b1;
    chk_vec("R8", "held ctr_a", ctr_a, e);
    chk_vec("R8", "held ctr_b", ctr_b, '0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    e = '0; e[140] = 1'b1;
    chk_vec("R8", "released ctr_b", ctr_b, e);
    chk_vec("R8", "released ctr_a", ctr_a, '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule